// File: doc/BRIEF.md
# Timebase Prescaler with Selectable Square-Wave and Periodic Pulse

This block turns a 32.768 kHz timebase into a family of slower rates. The timebase reaches the block as a one-clock enable, `tbEn`, in the system clock domain. It feeds a fixed prescaler chain that divides by 8, then by 64, then by 64. The fifteen counter bits of that chain serve as taps. The last bit completes one period per second.

A 4-bit rate code drives a 16-way multiplexer that picks one tap. The tap it picks drives two things:
- a square-wave output, which an enable bit can hold low;
- a one-clock periodic pulse that marks the end of every selected period.

A separate one-clock tick fires once per second, whatever the rate code. A downstream calendar stage uses it. A change of rate code is not applied at once. It waits for an edge at which the old and the new tap both finish a period, so the output never shows a shortened high or low phase.

Top module: `rtc_sqw_divider`

## Requirements
- R1: A rate code k from 1 to 15 selects prescaler bit k-1. While the output enable is set, `sqwOut` then has a period of 2^k timebase ticks and stays high for 2^(k-1) of them. The first tick after reset makes bit 0 high.
- R2: Rate code 0 holds `sqwOut` low and produces no `perPulse`.
- R3: With a nonzero active code k, `perPulse` is high for exactly one clock in every 2^k timebase ticks. It is high in the clock that follows the tick on which the selected tap falls.
- R4: While the registered output enable is clear, `sqwOut` stays low. `perPulse` keeps its normal rhythm.
- R5: `sqwEn` is registered, so a change on it shows at `sqwOut` one clock later.
- R6: Let m be the larger of the active code and the requested `rateSel`. A new `rateSel` becomes active only on a timebase tick at which the low m prescaler bits are all ones. On that tick the square wave is low afterwards, and it then starts a full period.
- R7: `tick1Hz` is high for one clock after every 32768th timebase tick, when the whole chain wraps. It does not depend on `rateSel` or `sqwEn`.
- R8: While `rst_n` is low, the following are held at zero: the prescaler, the active rate code and the output enable. As a result `sqwOut`, `perPulse` and `tick1Hz` are all low.
- R9: In a clock without `tbEn`, the prescaler does not advance, `sqwOut` does not change and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbEn | input | 1 | One-clock enable per 32.768 kHz timebase tick |
| rateSel | input | 4 | Requested rate code, 0 = off, 1..15 = tap 0..14 |
| sqwEn | input | 1 | Square-wave output enable |
| sqwOut | output | 1 | Selected square wave, low when disabled or off |
| perPulse | output | 1 | One-clock pulse at the end of each selected period |
| tick1Hz | output | 1 | One-clock pulse once per second of timebase |

## Verification
The bench builds the block with its default stage widths of 3, 6 and 6 bits. The full 15-bit chain, and so rate code 15 and the once-per-second wrap, therefore take part. Most of the run keeps `tbEn` high on every clock, so the chain wraps twice within about 70,000 cycles. Other stretches space `tbEn` out with idle clocks, which exercises the hold behaviour. Codes are switched in both directions, from fast to slow and slow to fast, in the middle of a period. This places the deferred switch point at both the old tap's boundary and the new tap's boundary.

// File: rtl/rtc_sqw_pkg.sv
package rtc_sqw_pkg;

  localparam int SEL_W = 4;
  localparam int SEL_N = 1 << SEL_W;

  // Strobes from control to datapath: active tap code and output gate.
  typedef struct packed {
    logic [SEL_W-1:0] tapSel;
    logic             outEn;
  } sqwStrobes_t;

endpackage

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         carryIn,
  output logic [W-1:0] cnt,
  output logic         carryOut
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (carryIn) cnt <= cnt + 1'b1;
  end

  assign carryOut = carryIn & (&cnt);

  // R9: the stage only moves when a carry arrives
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !carryIn |=> $stable(cnt));

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int ST1_W = 3,
  parameter int ST2_W = 6,
  parameter int ST3_W = 6,
  localparam int TAP_W = ST1_W + ST2_W + ST3_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbEn,
  output logic [TAP_W-1:0] taps,
  output logic [TAP_W-1:0] allOnes,
  output logic             wrap
);

  localparam int NSTG = 3;
  localparam int STW [NSTG] = '{ST1_W, ST2_W, ST3_W};

  function automatic int stOff(input int s);
    int acc = 0;
    for (int i = 0; i < s; i++) acc += STW[i];
    return acc;
  endfunction

  logic [NSTG:0] carry;
  assign carry[0] = tbEn;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    rtc_div_stage #(.W(STW[s])) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .carryIn (carry[s]),
      .cnt     (taps[stOff(s) +: STW[s]]),
      .carryOut(carry[s+1])
    );
  end

  // prefix AND: allOnes[i] set when taps[i:0] are all ones
  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < TAP_W; i++) begin
      run        = run & taps[i];
      allOnes[i] = run;
    end
  end

  assign wrap = carry[NSTG];

endmodule

// File: rtl/rtc_sqw_datapath.sv
module rtc_sqw_datapath
  import rtc_sqw_pkg::*;
#(
  parameter int ST1_W = 3,
  parameter int ST2_W = 6,
  parameter int ST3_W = 6,
  localparam int TAP_W = ST1_W + ST2_W + ST3_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbEn,
  input  sqwStrobes_t      strobes,
  output logic [TAP_W-1:0] allOnes,
  output logic             sqwOut,
  output logic             perPulse,
  output logic             tick1Hz
);

  logic [TAP_W-1:0] taps;
  logic             wrap;
  logic             tapBit;
  logic             tapDone;

  rtc_prescaler #(.ST1_W(ST1_W), .ST2_W(ST2_W), .ST3_W(ST3_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tbEn   (tbEn),
    .taps   (taps),
    .allOnes(allOnes),
    .wrap   (wrap)
  );

  // 16-way tap multiplexer; code 0 and codes beyond the chain select nothing
  always_comb begin
    tapBit  = 1'b0;
    tapDone = 1'b0;
    for (int k = 1; k < SEL_N; k++) begin
      if (k <= TAP_W && int'(strobes.tapSel) == k) begin
        tapBit  = taps[k-1];
        tapDone = allOnes[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perPulse <= 1'b0;
      tick1Hz  <= 1'b0;
    end else begin
      perPulse <= tbEn & tapDone;
      tick1Hz  <= wrap;
    end
  end

  assign sqwOut = strobes.outEn & tapBit;

  // R3: a period lasts at least two ticks, so the pulse never repeats back to back
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    perPulse |=> !perPulse);
  // R7: the wrap tick is one clock wide
  p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick1Hz |=> !tick1Hz);
  // R2: code 0 yields no pulse in the following clock
  p_off_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.tapSel == '0) |=> !perPulse);
  // R4: gate closed means output low
  p_gate_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.outEn |-> !sqwOut);
  // R9: no tick, no output movement
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbEn && $stable(strobes)) |=> $stable(sqwOut));

endmodule

// File: rtl/rtc_sqw_ctrl.sv
module rtc_sqw_ctrl
  import rtc_sqw_pkg::*;
#(
  parameter int TAP_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbEn,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             sqwEn,
  input  logic [TAP_W-1:0] allOnes,
  output sqwStrobes_t      strobes
);

  logic [SEL_W-1:0] actSel;
  logic [SEL_W-1:0] maxSel;
  logic             enReg;
  logic             boundary;

  assign maxSel = (rateSel > actSel) ? rateSel : actSel;

  // switch point: both old and new taps close a period on this tick
  always_comb begin
    boundary = (maxSel == '0);
    for (int k = 1; k < SEL_N; k++) begin
      if (k <= TAP_W && int'(maxSel) == k) boundary = allOnes[k-1];
    end
    boundary = boundary & tbEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actSel <= '0;
      enReg  <= 1'b0;
    end else begin
      enReg <= sqwEn;
      if (boundary) actSel <= rateSel;
    end
  end

  assign strobes.tapSel = actSel;
  assign strobes.outEn  = enReg;

  // R6: the active code moves only on a timebase tick
  p_switch_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(actSel) |-> $past(tbEn));
  // R6: the code that becomes active is the one that was requested
  p_switch_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(actSel) |-> (actSel == $past(rateSel)));
  // R5: enable follows its input one clock later
  p_en_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sqwEn |=> strobes.outEn);

endmodule

// File: rtl/rtc_sqw_divider.sv
module rtc_sqw_divider
  import rtc_sqw_pkg::*;
#(
  parameter int ST1_W = 3,
  parameter int ST2_W = 6,
  parameter int ST3_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tbEn,
  input  logic [3:0] rateSel,
  input  logic       sqwEn,
  output logic       sqwOut,
  output logic       perPulse,
  output logic       tick1Hz
);

  localparam int TAP_W = ST1_W + ST2_W + ST3_W;

  sqwStrobes_t      strobes;
  logic [TAP_W-1:0] allOnes;

  rtc_sqw_ctrl #(.TAP_W(TAP_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tbEn   (tbEn),
    .rateSel(rateSel),
    .sqwEn  (sqwEn),
    .allOnes(allOnes),
    .strobes(strobes)
  );

  rtc_sqw_datapath #(.ST1_W(ST1_W), .ST2_W(ST2_W), .ST3_W(ST3_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tbEn    (tbEn),
    .strobes (strobes),
    .allOnes (allOnes),
    .sqwOut  (sqwOut),
    .perPulse(perPulse),
    .tick1Hz (tick1Hz)
  );

endmodule

// File: tb/test_rtc_sqw_divider.sv
module test_rtc_sqw_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbEn = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic       sqwEn = 1'b0;
  logic       sqwOut, perPulse, tick1Hz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  rtc_sqw_divider i_rtc_sqw_divider (
    .clk(clk), .rst_n(rst_n), .tbEn(tbEn), .rateSel(rateSel),
    .sqwEn(sqwEn), .sqwOut(sqwOut), .perPulse(perPulse), .tick1Hz(tick1Hz)
  );

  // behavioural reference: integer tick count and active code
  int mCnt = 0, mAct = 0;
  bit mEn = 0, mPulse = 0, mTick = 0;

  always @(posedge clk) begin
    int mx, per, pm;
    if (!rst_n) begin
      mCnt <= 0; mAct <= 0; mEn <= 0; mPulse <= 0; mTick <= 0;
    end else begin
      mx  = (int'(rateSel) > mAct) ? int'(rateSel) : mAct;
      pm  = 1 << mx;
      per = 1 << mAct;
      mPulse <= tbEn && mAct != 0 && (mCnt % per) == per - 1;
      mTick  <= tbEn && mCnt == 32767;
      mEn    <= sqwEn;
      if (tbEn) mCnt <= (mCnt + 1) % 32768;
      if (tbEn && (mCnt % pm) == pm - 1) mAct <= int'(rateSel);
    end
  end

  function automatic bit expSqw();
    return mEn && mAct != 0 && (((mCnt >> (mAct - 1)) & 1) == 1);
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sqwOut == expSqw(), "R1 sqwOut", sqwOut, expSqw());
      check(perPulse == mPulse, "R3 perPulse", perPulse, mPulse);
      check(tick1Hz == mTick, "R7 tick1Hz", tick1Hz, mTick);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic report();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  int pc;
  bit sawHigh;
  bit held;

  initial begin
    // R8: reset state with enable and rate requested
    sqwEn = 1; rateSel = 4'd1; tbEn = 1;
    cyc(4);
    @(negedge clk);
    check(!sqwOut && !perPulse && !tick1Hz, "R8 reset outputs", sqwOut, 0);
    cyc(1);
    rst_n = 1;

    // R1/R6: start at code 1, then move slower and faster mid-period
    cyc(40);
    rateSel = 4'd3; cyc(37);
    rateSel = 4'd7; cyc(300);
    rateSel = 4'd2; cyc(150);

    // R3: count pulses at code 3 over 64 ticks, aligned after switch settles
    rateSel = 4'd3; cyc(20);
    pc = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); if (perPulse) pc++;
    end
    check(pc == 8, "R3 pulse count code3", pc, 8);

    // R2: code 0 silences both outputs
    rateSel = 4'd0; cyc(20);
    pc = 0; sawHigh = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (perPulse) pc++; if (sqwOut) sawHigh = 1;
    end
    check(pc == 0, "R2 no pulse", pc, 0);
    check(!sawHigh, "R2 sqw low", sawHigh, 0);

    // R4: enable clear, pulse keeps running
    rateSel = 4'd2; sqwEn = 0; cyc(20);
    pc = 0; sawHigh = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); if (perPulse) pc++; if (sqwOut) sawHigh = 1;
    end
    check(pc == 16, "R4 pulse with gate off", pc, 16);
    check(!sawHigh, "R4 sqw held low", sawHigh, 0);

    // R5: enable latency of one clock
    rateSel = 4'd5; cyc(40);
    sqwEn = 1;
    cyc(1);
    @(negedge clk);
    check(sqwOut == expSqw(), "R5 enable latency", sqwOut, expSqw());

    // R9: gapped timebase, then a long idle stretch
    rateSel = 4'd1; cyc(10);
    for (int i = 0; i < 200; i++) begin
      tbEn = (i % 3 == 0); cyc(1);
    end
    tbEn = 0; cyc(1);
    @(negedge clk); held = sqwOut; pc = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (perPulse) pc++;
      if (sqwOut != held) pc++;
    end
    check(pc == 0, "R9 frozen without tbEn", pc, 0);

    // R7: run two full wraps at code 15, rate changes do not move the tick
    tbEn = 1; rateSel = 4'd15;
    pc = 0;
    for (int i = 0; i < 66000; i++) begin
      @(negedge clk); if (tick1Hz) pc++;
      if (i == 20000) rateSel = 4'd6;
      if (i == 40000) rateSel = 4'd15;
    end
    check(pc == 2, "R7 wrap ticks", pc, 2);

    // R6: slow-to-fast request mid-period at code 15 waits for code 15 boundary
    rateSel = 4'd1;
    cyc(100);
    @(negedge clk);
    check(perPulse == mPulse, "R6 deferred switch", perPulse, mPulse);

    // R8: reset in the middle of activity
    rst_n = 0; cyc(1);
    @(negedge clk);
    check(!sqwOut && !perPulse && !tick1Hz, "R8 reset mid-run", sqwOut, 0);
    rst_n = 1; rateSel = 4'd4; cyc(200);

    report();
  end

endmodule